// File: doc/BRIEF.md
# Amplitude-Modulated Timecode Carrier Synthesizer

This block turns a stream of timecode symbols into 8-bit unsigned samples of a sine carrier whose amplitude is keyed per symbol. An external DAC or PWM stage converts the samples to an analog signal. A sample-rate strobe (`sample_en`) advances the waveform. Each strobe produces one sample, so 256 strobes make one carrier period.

Each symbol lasts ten carrier periods. The symbol type sets how many of those periods, counted from the start of the symbol, use the large amplitude. The remaining periods use one third of that amplitude. Both amplitudes are centred on midscale. Symbols enter over a valid/ready handshake. The block accepts a symbol only on the strobe at a symbol boundary, so a new symbol always starts at carrier phase zero, right after the last sample of the previous one.

If no symbol is waiting at a boundary, the output rests at midscale and an underrun flag is raised. A synchronous abort stops generation on the next clock edge.

Top module: `irigam_synth`

## Requirements
- R1: While reset is held and after its release, before any strobe, `sample_out` is 128, `underrun` is 0 and `sym_ready` is 0.
- R2: `sym_kind` encoding: 2'b00 is a zero symbol, 2'b01 is a one symbol, 2'b10 is a marker symbol, and 2'b11 is treated as a zero symbol.
- R3: An accepted symbol produces exactly 2560 samples, one per strobe. The j-th sample of a period (j = 0..255) is round-half-up(128 + A*sin(2*pi*j/256)), with pi taken as 3.14159265358979.
- R4: The large amplitude A = 127 is used for the first 2 periods of a zero symbol, the first 5 periods of a one symbol and the first 8 periods of a marker symbol. The remaining periods of each symbol use A = 127/3.
- R5: Every sample lies in the range 1 to 255, inclusive.
- R6: `sym_ready` is 1 only in a cycle with `sample_en` = 1 and `abort` = 0 while the block is at a symbol boundary (idle, or emitting the last sample of a symbol). A handshake on that edge makes the next output the phase-0 sample (128) of the new symbol, with no gap and no repeated sample.
- R7: In a cycle with `sample_en` = 0 and `abort` = 0, `sample_out` does not change.
- R8: A strobe at a boundary with no valid symbol makes `sample_out` 128 and sets `underrun` to 1. `underrun` stays 1, with the output at 128, until a symbol is accepted or an abort occurs.
- R9: `abort` = 1 on a clock edge sets the output to 128, clears `underrun` and discards the symbol in progress. The next strobe then finds the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_en | input | 1 | Sample-rate strobe |
| abort | input | 1 | Synchronous stop; output forced to midscale |
| sym_valid | input | 1 | A symbol is offered |
| sym_ready | output | 1 | The symbol is taken on this edge |
| sym_kind | input | 2 | Symbol type (R2) |
| sample_out | output | 8 | Unsigned carrier sample |
| underrun | output | 1 | Boundary reached with no symbol waiting |

## Verification
The checker watches several rules on every cycle: the output holds between strobes, `sym_ready` rises only on a strobe without abort, an accepted symbol starts at midscale, an underrun pins the output to midscale, an abort lands on midscale with the flag clear, and every sample stays within range. The bench covers what needs a full reference waveform. It checks the exact sample values, the split between large-amplitude and small-amplitude periods for each symbol type, seamless back-to-back joins at two strobe rates, the reserved code, and recovery after an abort that lands mid-symbol.

// File: rtl/irigam_pkg.sv
package irigam_pkg;
  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_MARK = 2'b10,
    SYM_RSVD = 2'b11
  } sym_kind_e;

  localparam real PI_VAL = 3.14159265358979;
endpackage

// File: rtl/irigam_wave_rom.sv
module irigam_wave_rom #(
  parameter int SAMPLE_W = 8,
  parameter int N_SAMP   = 256,
  parameter int AMP_DIV  = 3,
  localparam int IDX_W   = $clog2(N_SAMP)
) (
  input  logic [IDX_W-1:0]    idx,
  input  logic                big,
  output logic [SAMPLE_W-1:0] val
);
  import irigam_pkg::*;

  localparam int  MID    = 1 << (SAMPLE_W - 1);
  localparam real AMP_LG = real'(MID - 1);
  localparam real AMP_SM = AMP_LG / real'(AMP_DIV);

  logic [SAMPLE_W-1:0] tbl_lg [N_SAMP];
  logic [SAMPLE_W-1:0] tbl_sm [N_SAMP];

  // Both tables are computed at elaboration from the sine function.
  for (genvar i = 0; i < N_SAMP; i++) begin : g_tbl
    localparam real ANG = 2.0 * PI_VAL * real'(i) / real'(N_SAMP);
    localparam int  VLG = $rtoi(real'(MID) + AMP_LG * $sin(ANG) + 0.5);
    localparam int  VSM = $rtoi(real'(MID) + AMP_SM * $sin(ANG) + 0.5);
    assign tbl_lg[i] = VLG[SAMPLE_W-1:0];
    assign tbl_sm[i] = VSM[SAMPLE_W-1:0];
  end

  assign val = big ? tbl_lg[idx] : tbl_sm[idx];
endmodule

// File: rtl/irigam_sequencer.sv
module irigam_sequencer #(
  parameter int N_SAMP    = 256,
  parameter int N_PER     = 10,
  parameter int LG_ZERO   = 2,
  parameter int LG_ONE    = 5,
  parameter int LG_MARK   = 8,
  localparam int IDX_W    = $clog2(N_SAMP),
  localparam int PER_W    = $clog2(N_PER)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             abort,
  input  logic             sym_valid,
  input  logic [1:0]       sym_kind,
  output logic             sym_ready,
  output logic             nxt_active,
  output logic [IDX_W-1:0] nxt_phase,
  output logic             nxt_big,
  output logic             underrun
);
  import irigam_pkg::*;

  localparam logic [IDX_W-1:0] LAST_PH  = IDX_W'(N_SAMP - 1);
  localparam logic [PER_W-1:0] LAST_PER = PER_W'(N_PER - 1);

  logic             act_q, act_d;
  logic [IDX_W-1:0] ph_q, ph_d;
  logic [PER_W-1:0] per_q, per_d;
  sym_kind_e        kind_q, kind_d;
  logic             und_q, und_d;
  logic             boundary;

  function automatic logic [PER_W-1:0] big_periods(input sym_kind_e k);
    case (k)
      SYM_ONE:  return PER_W'(LG_ONE);
      SYM_MARK: return PER_W'(LG_MARK);
      default:  return PER_W'(LG_ZERO);
    endcase
  endfunction

  assign boundary  = !act_q || (ph_q == LAST_PH && per_q == LAST_PER);
  assign sym_ready = sample_en && !abort && boundary;

  always_comb begin
    act_d  = act_q;
    ph_d   = ph_q;
    per_d  = per_q;
    kind_d = kind_q;
    und_d  = und_q;
    if (abort) begin
      act_d = 1'b0;
      und_d = 1'b0;
    end else if (sample_en) begin
      if (boundary) begin
        if (sym_valid) begin
          act_d  = 1'b1;
          ph_d   = '0;
          per_d  = '0;
          kind_d = sym_kind_e'(sym_kind);
          und_d  = 1'b0;
        end else begin
          act_d = 1'b0;
          und_d = 1'b1;
        end
      end else begin
        ph_d = ph_q + 1'b1;
        if (ph_q == LAST_PH) per_d = per_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ph_q   <= '0;
      per_q  <= '0;
      kind_q <= SYM_ZERO;
      und_q  <= 1'b0;
    end else if (sample_en || abort) begin
      act_q  <= act_d;
      ph_q   <= ph_d;
      per_q  <= per_d;
      kind_q <= kind_d;
      und_q  <= und_d;
    end
  end

  assign nxt_active = act_d;
  assign nxt_phase  = ph_d;
  assign nxt_big    = per_d < big_periods(kind_d);
  assign underrun   = und_q;
endmodule

// File: rtl/irigam_synth.sv
module irigam_synth #(
  parameter int SAMPLE_W = 8,
  parameter int N_SAMP   = 256,
  parameter int N_PER    = 10,
  parameter int LG_ZERO  = 2,
  parameter int LG_ONE   = 5,
  parameter int LG_MARK  = 8,
  parameter int AMP_DIV  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                abort,
  input  logic                sym_valid,
  output logic                sym_ready,
  input  logic [1:0]          sym_kind,
  output logic [SAMPLE_W-1:0] sample_out,
  output logic                underrun
);
  localparam int IDX_W = $clog2(N_SAMP);
  localparam logic [SAMPLE_W-1:0] MID = SAMPLE_W'(1 << (SAMPLE_W - 1));

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                nxt_active, nxt_big;
  logic [IDX_W-1:0]    nxt_phase;
  logic [SAMPLE_W-1:0] rom_val, smp_d, smp_q;
  logic                upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irigam_sequencer #(
    .N_SAMP(N_SAMP), .N_PER(N_PER),
    .LG_ZERO(LG_ZERO), .LG_ONE(LG_ONE), .LG_MARK(LG_MARK)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .sample_en(sample_en), .abort(abort),
    .sym_valid(sym_valid), .sym_kind(sym_kind), .sym_ready(sym_ready),
    .nxt_active(nxt_active), .nxt_phase(nxt_phase), .nxt_big(nxt_big),
    .underrun(underrun)
  );

  irigam_wave_rom #(
    .SAMPLE_W(SAMPLE_W), .N_SAMP(N_SAMP), .AMP_DIV(AMP_DIV)
  ) u_rom (
    .idx(nxt_phase), .big(nxt_big), .val(rom_val)
  );

  assign upd   = sample_en || abort;
  assign smp_d = (nxt_active && !abort) ? rom_val : MID;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  smp_q <= MID;
    else if (upd)    smp_q <= smp_d;
  end

  assign sample_out = smp_q;
endmodule

// File: rtl/irigam_synth_chk.sv
module irigam_synth_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_en,
  input logic                abort,
  input logic                sym_valid,
  input logic                sym_ready,
  input logic [SAMPLE_W-1:0] sample_out,
  input logic                underrun
);
  localparam logic [SAMPLE_W-1:0] MID  = SAMPLE_W'(1 << (SAMPLE_W - 1));
  localparam logic [SAMPLE_W-1:0] LOWB = SAMPLE_W'(1);

  a_r6_ready_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sym_ready |-> (sample_en && !abort));

  a_r6_start_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (sample_out == MID && !underrun));

  a_r7_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !abort) |=> $stable(sample_out));

  a_r8_underrun_mid: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (sample_out == MID));

  a_r9_abort_mid: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (sample_out == MID && !underrun));

  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    sample_out >= LOWB);
endmodule

bind irigam_synth irigam_synth_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .abort(abort),
  .sym_valid(sym_valid), .sym_ready(sym_ready),
  .sample_out(sample_out), .underrun(underrun)
);

// File: tb/sim_irigam_synth.sv
module sim_irigam_synth;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_en = 1'b0;
  logic       abort = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym_kind = 2'b00;
  logic       sym_ready;
  logic [7:0] sample_out;
  logic       underrun;

  int n_vec = 0;
  int n_bad = 0;
  int en_div = 1;
  int en_cnt = 0;
  bit run_en = 1'b0;
  bit mon_on = 1'b0;
  int cyc = 0;
  logic [7:0] expq[$];
  logic en_q = 1'b0, ab_q = 1'b0, hs = 1'b0;
  logic [7:0] prev_out = 8'd128;

  irigam_synth u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .abort(abort),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_kind(sym_kind),
    .sample_out(sample_out), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_val(input int j, input bit big);
    real a;
    a = big ? 127.0 : 127.0 / 3.0;
    return 8'($rtoi(128.0 + a * $sin(2.0 * 3.14159265358979 * j / 256.0) + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Strobe generator
  always @(negedge clk) begin
    if (run_en) begin
      sample_en <= (en_cnt % en_div) == 0;
      en_cnt    <= en_cnt + 1;
    end else begin
      sample_en <= 1'b0;
    end
  end

  always @(posedge clk) begin
    en_q <= sample_en && !abort && rst_n;
    ab_q <= abort;
    hs   <= sym_valid && sym_ready;
    cyc  <= cyc + 1;
  end

  // Monitor: compares each produced sample with the scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (ab_q) begin
        check(sample_out == 8'd128, "R9 abort output", sample_out, 128);
        check(underrun == 1'b0, "R9 abort clears underrun", underrun, 0);
      end else if (en_q) begin
        if (expq.size() > 0) begin
          logic [7:0] e;
          e = expq.pop_front();
          check(sample_out == e, "R3/R4 sample value", sample_out, e);
          check(underrun == 1'b0, "R8 no underrun while active", underrun, 0);
        end else begin
          check(sample_out == 8'd128, "R8 underrun output", sample_out, 128);
          check(underrun == 1'b1, "R8 underrun flag", underrun, 1);
        end
      end else begin
        check(sample_out == prev_out, "R7 hold without strobe", sample_out, prev_out);
      end
    end
    prev_out = sample_out;
  end

  task automatic send(input logic [1:0] k);
    int nbig;
    nbig = (k == 2'b01) ? 5 : (k == 2'b10) ? 8 : 2;  // R2: 11 acts as zero
    for (int p = 0; p < 10; p++)
      for (int j = 0; j < 256; j++)
        expq.push_back(ref_val(j, p < nbig));
    sym_kind  = k;
    sym_valid = 1'b1;
    do begin
      @(posedge clk);
      #1;
    end while (!hs);
    sym_valid = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() > 0) @(negedge clk);
    repeat (4 * en_div + 2) @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc > WATCHDOG);
    n_bad++;
    n_vec++;
    $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sample_out == 8'd128, "R1 reset output", sample_out, 128);
    check(underrun == 1'b0, "R1 reset underrun", underrun, 0);
    check(sym_ready == 1'b0, "R1 reset ready", sym_ready, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sample_out == 8'd128, "R1 after release", sample_out, 128);
    check(sym_ready == 1'b0, "R1 ready without strobe", sym_ready, 0);
    mon_on = 1'b1;

    // Strobe every cycle, back to back: zero, one, marker, reserved (R2, R6)
    en_div = 1;
    run_en = 1'b1;
    @(negedge clk); #1;
    send(2'b00);
    send(2'b01);
    send(2'b10);
    send(2'b11);
    drain();
    check(underrun == 1'b1, "R8 flag after stream end", underrun, 1);

    // Sparse strobes (R7): one then marker
    en_div = 3;
    @(negedge clk); #1;
    send(2'b01);
    send(2'b10);
    drain();
    check(sample_out == 8'd128, "R8 output after sparse stream", sample_out, 128);

    // Abort mid-symbol (R9)
    en_div = 1;
    @(negedge clk); #1;
    send(2'b00);
    repeat (700) @(negedge clk);
    #1;
    abort = 1'b1;
    expq.delete();
    @(negedge clk);
    #1 abort = 1'b0;
    repeat (20) @(negedge clk);
    check(underrun == 1'b1, "R9 idle after abort", underrun, 1);

    // Recovery after abort
    #1;
    send(2'b10);
    drain();
    check(sample_out == 8'd128, "R8 final idle", sample_out, 128);

    run_en = 1'b0;
    mon_on = 1'b0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule